// File: doc/BRIEF.md
# Buffered Serial Register Control Port

This block is a serial slave port that gives a host access to a small bank of 32-bit configuration registers. With the chip select held low, the host shifts in an instruction byte, which carries a read/write flag and a register address, and then 32 data bits. A written word goes into a shadow buffer. It reaches the active register only when the host raises the update input. A read always returns the active value. Several complete cycles may follow one another under a single chip-select assertion.

The serial inputs, the update input and the abort input are all sampled by the core clock. Each passes through a two-flop synchroniser. The block detects SCLK edges and the update edge in the core domain. Register 0 is the control register. Its bit 0 sets the bit order, for the instruction byte as well as the data. Its bit 1 selects between two modes: a 3-wire mode, where read data leaves on a separate output, and a 2-wire mode, where read data is driven back on the shared data line. Both control bits take effect only after an update.

The abort input throws away the cycle in progress without disturbing any register. The next cycle then begins with a fresh instruction byte.

Top module: `sercfg_port`

## Requirements
- R1: After reset, every active register reads 0. The port runs MSB first in 3-wire mode, and both output enables are low.
- R2: Instruction bit 7 = 1 means read and 0 means write. Bits 6..0 are the address. In MSB-first order, instruction bit 7 is shifted first and data bit 31 is shifted first. Input bits are taken on SCLK rising edges.
- R3: A write changes only the shadow copy. Reads return the active value, which stays unchanged until an update rising edge copies all shadow registers into the active ones.
- R4: Only a rising edge of the update input copies. While the input stays high, later writes are not copied until it goes low and rises again.
- R5: With active control bit 0 = 1, the instruction byte and the data are both shifted LSB first, starting with bit 0.
- R6: In a read data phase, active control bit 1 = 0 (3-wire) drives data on sdo_o with sdo_oe = 1 and sdio_oe = 0. Bit 1 = 1 (2-wire) drives data on sdio_o with sdio_oe = 1 and sdo_oe = 0. The two enables are never high together.
- R7: Both output enables are low while chip select is high, during the instruction byte and during a write.
- R8: A high abort input cancels the cycle in progress and leaves every shadow and active register unchanged. After it returns low, the next bit is taken as the first bit of an instruction byte.
- R9: Raising chip select mid-cycle discards the partial cycle. The next cycle starts at the instruction byte.
- R10: The port works whether SCLK idles low or high, and whether or not SCLK pauses between the instruction byte and the data.
- R11: A write to an address of NUM_REGS or above is ignored, and a read of such an address returns 0.
- R12: Back-to-back cycles with chip select held low are each decoded from a fresh instruction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data in (shared line, input side) |
| sdio_o | output | 1 | Read data on the shared line in 2-wire mode |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo_o | output | 1 | Read data on the separate output in 3-wire mode |
| sdo_oe | output | 1 | Drive enable for the separate output |
| update | input | 1 | Rising edge copies shadow registers to active |
| abort | input | 1 | Active-high cancel of the current cycle |

## Verification
An SCLK edge reaches the shifter 3 core cycles after the pin moves: two synchroniser stages and one edge register. A read bit reaches the pins one output register later, about 4 cycles after SCLK falls. The bench keeps each SCLK level for 6 core cycles and samples the data line just before the rising edge, so every bit has settled. An update is visible about 4 cycles after it rises. A write lands about 4 cycles after the last SCLK rise. The bench therefore waits at least 8 cycles after each update pulse and after raising chip select before it starts the next read, so every compared value is already due.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int INSTR_BITS = 8;
  localparam int ADDR_BITS  = 7;

  typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_e;

  localparam int CTRL_LSB_BIT  = 0;
  localparam int CTRL_WIRE_BIT = 1;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
  import sercfg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 abort,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 din,
  input  logic                 lsb_first,
  input  logic [DW-1:0]        rd_data,
  output logic                 wr_en,
  output logic [ADDR_BITS-1:0] addr,
  output logic [DW-1:0]        wr_data,
  output logic                 dout,
  output logic                 dout_en
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_INS = CW'(INSTR_BITS - 1);
  localparam logic [CW-1:0] LAST_DAT = CW'(DW - 1);

  phase_e                phase;
  logic [CW-1:0]         cnt;
  logic [INSTR_BITS-1:0] ins_sh, ins_nx;
  logic [DW-1:0]         dat_sh, dat_nx, out_sh;
  logic                  is_rd, loaded;

  always_comb begin
    ins_nx = lsb_first ? {din, ins_sh[INSTR_BITS-1:1]} : {ins_sh[INSTR_BITS-2:0], din};
    dat_nx = lsb_first ? {din, dat_sh[DW-1:1]} : {dat_sh[DW-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_sh  <= '0;
      dat_sh  <= '0;
      out_sh  <= '0;
      addr    <= '0;
      wr_data <= '0;
      is_rd   <= 1'b0;
    end
    if (rst || cs_n || abort) begin
      phase   <= PH_INSTR;
      cnt     <= '0;
      loaded  <= 1'b0;
      dout_en <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        if (phase == PH_INSTR) begin
          ins_sh <= ins_nx;
          if (cnt == LAST_INS) begin
            is_rd  <= ins_nx[INSTR_BITS-1];
            addr   <= ins_nx[ADDR_BITS-1:0];
            phase  <= PH_DATA;
            cnt    <= '0;
            loaded <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          dat_sh <= dat_nx;
          if (cnt == LAST_DAT) begin
            phase   <= PH_INSTR;
            cnt     <= '0;
            dout_en <= 1'b0;
            wr_en   <= ~is_rd;
            wr_data <= dat_nx;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (fall && phase == PH_DATA && is_rd) begin
        if (!loaded) begin
          out_sh  <= rd_data;
          loaded  <= 1'b1;
          dout_en <= 1'b1;
        end else begin
          out_sh <= lsb_first ? (out_sh >> 1) : (out_sh << 1);
        end
      end
    end
  end

  assign dout = lsb_first ? out_sh[0] : out_sh[DW-1];
endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
  import sercfg_pkg::*;
#(
  parameter int NREG = 4,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 upd,
  output logic [DW-1:0]        rd_data,
  output logic [DW-1:0]        ctrl,
  output logic [NREG*DW-1:0]   active_flat
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] shadow [NREG];
  logic [DW-1:0] active [NREG];
  logic          in_range;

  assign in_range = addr < ADDR_BITS'(NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[g] <= '0;
        active[g] <= '0;
      end else begin
        if (wr_en && in_range && addr[IW-1:0] == IW'(g)) shadow[g] <= wr_data;
        if (upd) active[g] <= shadow[g];
      end
    end
    assign active_flat[g*DW +: DW] = active[g];
  end

  assign rd_data = in_range ? active[addr[IW-1:0]] : '0;
  assign ctrl    = active[0];
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo_o,
  output logic sdo_oe,
  input  logic update,
  input  logic abort
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0]       raw_in, syn;
  logic                   cs_n_s, sclk_s, din_s, upd_s, abort_s;
  logic                   sclk_q, upd_q;
  logic                   rise, fall, upd_pulse;
  logic                   wr_en, dout, dout_en;
  logic [ADDR_BITS-1:0]   addr;
  logic [DATA_W-1:0]      wr_data, rd_data, ctrl_q;
  logic [NUM_REGS*DATA_W-1:0] active_flat;

  assign raw_in = {abort, update, sdio_i, sclk, cs_n};

  sercfg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(NSYNC'(1))) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign {abort_s, upd_s, din_s, sclk_s, cs_n_s} = syn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      upd_q  <= upd_s;
    end
  end

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign upd_pulse = upd_s & ~upd_q;

  sercfg_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .cs_n(cs_n_s), .abort(abort_s),
    .rise(rise), .fall(fall), .din(din_s),
    .lsb_first(ctrl_q[CTRL_LSB_BIT]), .rd_data(rd_data),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .dout(dout), .dout_en(dout_en)
  );

  sercfg_regbank #(.NREG(NUM_REGS), .DW(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .upd(upd_pulse), .rd_data(rd_data), .ctrl(ctrl_q), .active_flat(active_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdio_o  <= 1'b0;
      sdio_oe <= 1'b0;
      sdo_o   <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      sdio_o  <= dout;
      sdo_o   <= dout;
      sdio_oe <= dout_en & ctrl_q[CTRL_WIRE_BIT];
      sdo_oe  <= dout_en & ~ctrl_q[CTRL_WIRE_BIT];
    end
  end
endmodule

// File: rtl/sercfg_port_chk.sv
module sercfg_port_chk #(
  parameter int AW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sdio_oe,
  input logic          sdo_oe,
  input logic          two_wire,
  input logic          upd_pulse,
  input logic          abort_s,
  input logic          wr_en,
  input logic [AW-1:0] active_flat
);
  // R6
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe));

  // R6
  mode_line_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !two_wire);

  // R7
  cs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4) && $past(cs_n, 5))
    |-> (!sdio_oe && !sdo_oe));

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |=> $stable(active_flat));

  // R8
  abort_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    abort_s |=> !wr_en);
endmodule

bind sercfg_port sercfg_port_chk #(.AW(NUM_REGS*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
  .two_wire(ctrl_q[1]), .upd_pulse(upd_pulse), .abort_s(abort_s),
  .wr_en(wr_en), .active_flat(active_flat)
);

// File: tb/sercfg_port_test.sv
module sercfg_port_test;
  localparam int NREG = 4;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic update = 1'b0, abort = 1'b0;
  wire  sdio_o, sdio_oe, sdo_o, sdo_oe;

  always #10 clk = ~clk;

  sercfg_port #(.NUM_REGS(NREG), .DATA_W(32)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .update(update), .abort(abort)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit idle_hi = 1'b0;
  logic [31:0] exp_sh [NREG];
  logic [31:0] exp_act[NREG];

  function automatic logic [31:0] exp_read(input logic [6:0] a);
    return (a < 7'(NREG)) ? exp_act[a[1:0]] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic d, output logic q, output logic oe_io, output logic oe_o);
    sclk = 1'b0;
    sdio_i = d;
    step(6);
    q = exp_act[0][1] ? sdio_o : sdo_o;
    oe_io = sdio_oe;
    oe_o = sdo_oe;
    sclk = 1'b1;
    step(6);
  endtask

  task automatic xfer(input bit rd, input logic [6:0] a, input logic [31:0] wd,
                      input int stall, output logic [31:0] rv, output bit oe_good);
    logic [7:0] ins;
    logic q, e1, e2;
    bit lsb;
    bit tw;
    ins = {rd, a};
    lsb = exp_act[0][0];
    tw = exp_act[0][1];
    oe_good = 1'b1;
    rv = '0;
    for (int i = 0; i < 8; i++) begin
      sbit(lsb ? ins[i] : ins[7-i], q, e1, e2);
      if (e1 || e2) oe_good = 1'b0;
    end
    if (stall > 0) step(stall);
    for (int i = 0; i < 32; i++) begin
      int idx;
      idx = lsb ? i : 31 - i;
      sbit(wd[idx], q, e1, e2);
      rv[idx] = q;
      if (rd) begin
        if (tw ? !(e1 && !e2) : !(e2 && !e1)) oe_good = 1'b0;
      end else if (e1 || e2) oe_good = 1'b0;
    end
    if (!rd && a < 7'(NREG)) exp_sh[a[1:0]] = wd;
  endtask

  task automatic cs_low();
    sclk = idle_hi;
    step(3);
    cs_n = 1'b0;
    step(4);
  endtask

  task automatic cs_high();
    sclk = idle_hi;
    step(4);
    cs_n = 1'b1;
    step(10);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d, input string tag);
    logic [31:0] rv;
    bit ok;
    cs_low();
    xfer(1'b0, a, d, 0, rv, ok);
    cs_high();
    check({tag, " oe low in write"}, {31'b0, ok}, 32'd1);
  endtask

  task automatic do_read(input logic [6:0] a, input int stall, input string tag);
    logic [31:0] rv, ex;
    bit ok;
    ex = exp_read(a);
    cs_low();
    xfer(1'b1, a, 32'h0, stall, rv, ok);
    cs_high();
    check(tag, rv, ex);
    check({tag, " output enables"}, {31'b0, ok}, 32'd1);
  endtask

  task automatic pulse_update();
    update = 1'b1;
    step(6);
    update = 1'b0;
    step(8);
    for (int i = 0; i < NREG; i++) exp_act[i] = exp_sh[i];
  endtask

  initial begin
    logic [31:0] rv, v1, v2;
    bit ok;
    int unused;
    unused = $urandom(32'd20240611);
    for (int i = 0; i < NREG; i++) begin
      exp_sh[i] = '0;
      exp_act[i] = '0;
    end
    step(6);
    rst = 1'b0;
    step(6);

    // R1: reset state
    check("R1 oe after reset", {30'b0, sdio_oe, sdo_oe}, 32'd0);
    for (int i = 0; i < NREG; i++) do_read(7'(i), 0, "R1 reset value");

    // R2 R3: write to shadow only, then update
    do_write(7'd2, 32'hA5C3_0F81, "R2");
    do_read(7'd2, 0, "R3 active unchanged before update");
    pulse_update();
    do_read(7'd2, 0, "R2 readback after update");

    // R4: update held high copies once
    do_write(7'd1, 32'h1111_2222, "R4");
    update = 1'b1;
    step(8);
    for (int i = 0; i < NREG; i++) exp_act[i] = exp_sh[i];
    do_write(7'd1, 32'h3333_4444, "R4");
    do_read(7'd1, 0, "R4 no copy while update held");
    update = 1'b0;
    step(8);
    pulse_update();
    do_read(7'd1, 0, "R4 copy on next edge");

    // R11: out-of-range address
    do_write(7'h7F, 32'hDEAD_BEEF, "R11");
    do_write(7'h04, 32'hCAFE_F00D, "R11");
    pulse_update();
    do_read(7'h7F, 0, "R11 read out of range");
    do_read(7'd2, 0, "R11 in-range unchanged");

    // R10: idle high and a stall between phases
    idle_hi = 1'b1;
    do_write(7'd3, 32'h0BAD_F00D, "R10");
    pulse_update();
    do_read(7'd3, 40, "R10 idle high with stall");
    idle_hi = 1'b0;
    do_read(7'd3, 40, "R10 idle low with stall");

    // R12: two cycles under one chip select
    cs_low();
    xfer(1'b0, 7'd2, 32'h7E57_0001, 0, rv, ok);
    xfer(1'b1, 7'd2, 32'h0, 0, rv, ok);
    cs_high();
    check("R12 second cycle reads active", rv, 32'hA5C3_0F81);
    check("R12 second cycle enables", {31'b0, ok}, 32'd1);
    pulse_update();
    do_read(7'd2, 0, "R12 first cycle wrote shadow");

    // R9: partial cycle dropped by chip select
    cs_low();
    for (int i = 0; i < 13; i++) begin
      logic q, e1, e2;
      sbit(i[0], q, e1, e2);
    end
    cs_high();
    do_write(7'd1, 32'h5A5A_0001, "R9");
    pulse_update();
    do_read(7'd1, 0, "R9 clean cycle after partial");

    // R8: abort mid-data, then a new instruction under the same select
    v1 = exp_act[2];
    cs_low();
    begin
      logic q, e1, e2;
      logic [7:0] ins;
      ins = {1'b0, 7'd2};
      for (int i = 0; i < 8; i++) sbit(ins[7-i], q, e1, e2);
      for (int i = 0; i < 10; i++) sbit(1'b1, q, e1, e2);
    end
    abort = 1'b1;
    step(6);
    abort = 1'b0;
    step(6);
    xfer(1'b0, 7'd3, 32'h0C0F_FEE0, 0, rv, ok);
    cs_high();
    pulse_update();
    do_read(7'd2, 0, "R8 aborted write left register");
    check("R8 register value kept", exp_act[2], v1);
    do_read(7'd3, 0, "R8 cycle after abort decoded");

    // R5: switch to LSB first
    do_write(7'd0, 32'h0000_0001, "R5");
    pulse_update();
    do_write(7'd2, 32'h8000_0003, "R5");
    pulse_update();
    do_read(7'd2, 0, "R5 LSB first readback");
    do_read(7'd0, 0, "R5 control readback");

    // R6: 2-wire mode in LSB order, then back to 3-wire MSB
    do_write(7'd0, 32'h0000_0003, "R6");
    pulse_update();
    do_read(7'd2, 0, "R6 two-wire read");
    do_write(7'd0, 32'h0000_0002, "R6");
    pulse_update();
    do_read(7'd3, 0, "R6 two-wire MSB read");
    do_write(7'd0, 32'h0, "R6");
    pulse_update();
    do_read(7'd3, 0, "R6 three-wire read");

    // R7: idle enables
    check("R7 oe with select high", {30'b0, sdio_oe, sdo_oe}, 32'd0);

    // random mix
    for (int it = 0; it < 90; it++) begin
      int op;
      logic [6:0] a;
      op = int'($urandom % 5);
      case ($urandom % 6)
        0: a = 7'd0;
        1: a = 7'd1;
        2: a = 7'd2;
        3: a = 7'd3;
        4: a = 7'h10;
        default: a = 7'h7F;
      endcase
      idle_hi = ($urandom % 2) == 1;
      if (op < 2) begin
        v2 = $urandom;
        if (a == 7'd0) v2 = v2 & 32'h3;
        do_write(a, v2, "R3 random");
      end else if (op < 4) begin
        do_read(a, (($urandom % 3) == 0) ? 25 : 0, "R3 random read");
      end else begin
        pulse_update();
      end
    end
    check("R7 oe at end", {30'b0, sdio_oe, sdo_oe}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule